// File: doc/BRIEF.md
# Power Output Fault Latch and Diagnostic Readback

This block sits beside the command logic of a five-output power driver: four half-bridge outputs and one high-side output. For each output that is commanded on, it watches a "drain-source drop high" comparator flag. It runs a per-output trip timer. When the timer expires, it latches an overcurrent trip that forces that output off. The trip stays latched until the command controller presents a new write. Two global overrides act on top of the trips. An overvoltage flag forces every output off only while it is present. A thermal shutdown latch, set by a trip flag and released by a separate hysteresis-release flag, also forces every output off.

The latched trips are folded into two group flags: one for the half-bridge group and one for the high-side output. A host reads these flags over a 4-bit bus. When chip select is low and the read line is high, the block drives either the four half-bridge level comparator results or a status word. The status word holds a 2-bit fault code, the overtemperature warning and the high-side level. A write strobe that arrives during a read cycle is ignored, so reading never disturbs the output state. All outputs are registered.

Top module: `pwr_fault_diag`

## Requirements
- R1: For an output i with cmd_active[i] high, if drop_hi[i] is sampled high on TRIP_CYCLES consecutive clock edges, its trip latches on the last of those edges, and force_off[i] is high after that edge.
- R2: The trip timer of output i restarts from zero on any edge where drop_hi[i] or cmd_active[i] is low. An output that is not commanded active never trips.
- R3: An accepted wr_cmd clears every trip latch and every timer on that edge, and it takes precedence over a trip that would complete on the same edge. force_off then follows only the overvoltage and thermal overrides.
- R4: On every edge where ov_flag is sampled high, force_off becomes all ones. Once ov_flag is low again, force_off returns to the latched trips with no write needed.
- R5: tsd_trip sets a thermal shutdown latch that forces all of force_off high. tsd_release clears the latch only when tsd_trip is low. The latch holds while both flags are low.
- R6: In a read cycle with mode low, bus_dout[k] equals lvl_hi[k] for k = 0..3, registered one edge after the sample.
- R7: In a read cycle with mode high, bus_dout[1:0] is a fault code: 2'b00 means no trip, 2'b01 means a half-bridge trip (outputs 0..3), 2'b10 means a high-side trip (output 4), and 2'b11 means overvoltage. The half-bridge code wins over the high-side code. bus_dout[2] is ot_warn and bus_dout[3] is lvl_hi[4].
- R8: bus_oe is high one edge after an edge that samples sel_n low and rd_wr_n high, and low otherwise. bus_dout is 0 whenever bus_oe is low.
- R9: A wr_cmd sampled during a read cycle (sel_n low, rd_wr_n high) is ignored, so latched trips and force_off keep their values.
- R10: When overvoltage and a latched trip coexist, code 2'b11 is reported and the trip stays latched. After overvoltage clears, the trip code is reported again.
- R11: After reset, force_off, bus_oe and bus_dout are all zero and no trip or thermal latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_active | input | N_OUT | Output i is commanded on (not tristate) |
| drop_hi | input | N_OUT | Drain-source drop above threshold, per output |
| lvl_hi | input | N_OUT | Output level comparator result, per output |
| ov_flag | input | 1 | Supply overvoltage present |
| ot_warn | input | 1 | Overtemperature warning |
| tsd_trip | input | 1 | Thermal shutdown threshold crossed |
| tsd_release | input | 1 | Junction below shutdown minus hysteresis |
| sel_n | input | 1 | Bus chip select, active low |
| rd_wr_n | input | 1 | Bus direction, high for read |
| mode | input | 1 | Read selector: levels (0) or status word (1) |
| wr_cmd | input | 1 | New or repeated write command strobe |
| force_off | output | N_OUT | Per-output forced-off request |
| bus_oe | output | 1 | Readback data drive enable |
| bus_dout | output | 4 | Readback data |

## Verification
Two functions can act on the same edge. In the first case, a trip timer completes on the same edge where a write is accepted. The bench holds drop_hi high for TRIP_CYCLES-1 edges and raises wr_cmd for the final edge. It then expects force_off to stay low and the timer to need a full new window. In the second case, overvoltage arrives while a half-bridge trip is latched. The bench checks that force_off is all ones, that the code reads 2'b11, and that both the trip code and the single forced output come back after ov_flag drops. A behavioural model in the bench is compared against force_off, bus_oe and bus_dout on every clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Status word fault code, bit 0 maps to bus_dout[0].
  typedef enum logic [1:0] {
    FC_NONE = 2'b00,
    FC_HB   = 2'b01,
    FC_HS   = 2'b10,
    FC_OV   = 2'b11
  } fault_code_e;

  function automatic fault_code_e pick_code(input logic ov,
                                            input logic hb,
                                            input logic hs);
    if (ov)      return FC_OV;
    else if (hb) return FC_HB;
    else if (hs) return FC_HS;
    else         return FC_NONE;
  endfunction

endpackage

// File: rtl/pfd_trip_timer.sv
module pfd_trip_timer #(
  parameter int TRIP_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic drop,
  input  logic clr,
  output logic trip_d,
  output logic trip_q
);

  localparam int CW = (TRIP_CYCLES > 2) ? $clog2(TRIP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    trip_d = trip_q;
    if (clr) begin
      cnt_d  = '0;
      trip_d = 1'b0;
    end else if (!trip_q) begin
      if (arm && drop) begin
        if (cnt_q == LAST) trip_d = 1'b1;
        else               cnt_d  = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      trip_q <= trip_d;
    end
  end

endmodule

// File: rtl/pfd_thermal_latch.sv
module pfd_thermal_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_hot,
  input  logic cool_ok,
  output logic hot_d,
  output logic hot_q
);

  always_comb begin
    hot_d = hot_q;
    if (set_hot)      hot_d = 1'b1;
    else if (cool_ok) hot_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 1'b0;
    else     hot_q <= hot_d;
  end

endmodule

// File: rtl/pfd_readback.sv
module pfd_readback
  import pfd_pkg::*;
#(
  parameter int N_OUT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cycle,
  input  logic             mode,
  input  logic [N_OUT-1:0] lvl,
  input  logic             hb_flag,
  input  logic             hs_flag,
  input  logic             ov,
  input  logic             ot,
  output logic             oe,
  output logic [3:0]       dout
);

  localparam int HS = N_OUT - 1;

  fault_code_e code;
  logic [3:0]  word;

  always_comb begin
    code = pick_code(ov, hb_flag, hs_flag);
    if (!rd_cycle) word = 4'b0000;
    else if (mode) word = {lvl[HS], ot, code};
    else           word = lvl[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe   <= 1'b0;
      dout <= 4'b0000;
    end else begin
      oe   <= rd_cycle;
      dout <= word;
    end
  end

endmodule

// File: rtl/pwr_fault_diag.sv
module pwr_fault_diag #(
  parameter int N_OUT       = 5,
  parameter int TRIP_CYCLES = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] cmd_active,
  input  logic [N_OUT-1:0] drop_hi,
  input  logic [N_OUT-1:0] lvl_hi,
  input  logic             ov_flag,
  input  logic             ot_warn,
  input  logic             tsd_trip,
  input  logic             tsd_release,
  input  logic             sel_n,
  input  logic             rd_wr_n,
  input  logic             mode,
  input  logic             wr_cmd,
  output logic [N_OUT-1:0] force_off,
  output logic             bus_oe,
  output logic [3:0]       bus_dout
);

  localparam int HS_IDX = N_OUT - 1;

  logic             rd_cycle, wr_ok;
  logic [N_OUT-1:0] trip_d, trip_q;
  logic             hot_d, hot_q;
  logic             hb_flag, hs_flag;

  assign rd_cycle = !sel_n && rd_wr_n;
  assign wr_ok    = wr_cmd && !rd_cycle;

  for (genvar i = 0; i < N_OUT; i++) begin : g_timer
    pfd_trip_timer #(.TRIP_CYCLES(TRIP_CYCLES)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .arm    (cmd_active[i]),
      .drop   (drop_hi[i]),
      .clr    (wr_ok),
      .trip_d (trip_d[i]),
      .trip_q (trip_q[i])
    );
  end

  pfd_thermal_latch u_thermal (
    .clk     (clk),
    .rst     (rst),
    .set_hot (tsd_trip),
    .cool_ok (tsd_release),
    .hot_d   (hot_d),
    .hot_q   (hot_q)
  );

  assign hb_flag = |trip_q[HS_IDX-1:0];
  assign hs_flag = trip_q[HS_IDX];

  always_ff @(posedge clk) begin
    if (rst) force_off <= '0;
    else     force_off <= trip_d | {N_OUT{ov_flag}} | {N_OUT{hot_d}};
  end

  pfd_readback #(.N_OUT(N_OUT)) u_readback (
    .clk      (clk),
    .rst      (rst),
    .rd_cycle (rd_cycle),
    .mode     (mode),
    .lvl      (lvl_hi),
    .hb_flag  (hb_flag),
    .hs_flag  (hs_flag),
    .ov       (ov_flag),
    .ot       (ot_warn),
    .oe       (bus_oe),
    .dout     (bus_dout)
  );

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
  parameter int N_OUT = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [N_OUT-1:0] drop_hi,
  input logic [N_OUT-1:0] cmd_active,
  input logic             ov_flag,
  input logic             tsd_trip,
  input logic             sel_n,
  input logic             rd_wr_n,
  input logic             wr_cmd,
  input logic [N_OUT-1:0] force_off,
  input logic             bus_oe,
  input logic [3:0]       bus_dout,
  input logic [N_OUT-1:0] trip_q
);

  assert_ov_all_off_R4: assert property (@(posedge clk) disable iff (rst)
    ov_flag |=> (force_off == {N_OUT{1'b1}}));

  assert_tsd_all_off_R5: assert property (@(posedge clk) disable iff (rst)
    tsd_trip |=> (force_off == {N_OUT{1'b1}}));

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_dout == 4'b0000));

  assert_deselect_release_R8: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !bus_oe);

  assert_hs_trip_cause_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_q[N_OUT-1]) |-> $past(drop_hi[N_OUT-1] && cmd_active[N_OUT-1]));

  assert_write_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !(!sel_n && rd_wr_n)) |=> (trip_q == '0));

  assert_read_keeps_trip_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && !sel_n && rd_wr_n && trip_q[0]) |=> trip_q[0]);

endmodule

bind pwr_fault_diag pfd_checker #(.N_OUT(N_OUT)) u_pfd_checker (
  .clk        (clk),
  .rst        (rst),
  .drop_hi    (drop_hi),
  .cmd_active (cmd_active),
  .ov_flag    (ov_flag),
  .tsd_trip   (tsd_trip),
  .sel_n      (sel_n),
  .rd_wr_n    (rd_wr_n),
  .wr_cmd     (wr_cmd),
  .force_off  (force_off),
  .bus_oe     (bus_oe),
  .bus_dout   (bus_dout),
  .trip_q     (trip_q)
);

// File: tb/pwr_fault_diag_bench.sv
`timescale 1ns/1ps
module pwr_fault_diag_bench;

  localparam int N  = 5;
  localparam int TC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cmd_active = '0, drop_hi = '0, lvl_hi = '0;
  logic ov_flag = 0, ot_warn = 0, tsd_trip = 0, tsd_release = 0;
  logic sel_n = 1, rd_wr_n = 0, mode = 0, wr_cmd = 0;
  logic [N-1:0] force_off;
  logic bus_oe;
  logic [3:0] bus_dout;

  always #5 clk = ~clk;

  pwr_fault_diag #(.N_OUT(N), .TRIP_CYCLES(TC)) u_pwr_fault_diag (
    .clk(clk), .rst(rst), .cmd_active(cmd_active), .drop_hi(drop_hi),
    .lvl_hi(lvl_hi), .ov_flag(ov_flag), .ot_warn(ot_warn),
    .tsd_trip(tsd_trip), .tsd_release(tsd_release), .sel_n(sel_n),
    .rd_wr_n(rd_wr_n), .mode(mode), .wr_cmd(wr_cmd),
    .force_off(force_off), .bus_oe(bus_oe), .bus_dout(bus_dout));

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R11";

  // Behavioural reference model
  int       m_cnt [N];
  bit [N-1:0] m_trip;
  bit       m_hot;
  bit [N-1:0] m_force;
  bit       m_oe;
  bit [3:0] m_dout;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_trip = '0; m_hot = 0; m_force = '0; m_oe = 0; m_dout = 0;
    end else begin
      bit rd, wok;
      bit [1:0] code;
      rd  = !sel_n && rd_wr_n;
      wok = wr_cmd && !rd;
      if (ov_flag) code = 2'b11;
      else if (m_trip[3:0] != 0) code = 2'b01;
      else if (m_trip[4]) code = 2'b10;
      else code = 2'b00;
      m_oe = rd;
      if (!rd) m_dout = 4'b0;
      else if (mode) m_dout = {lvl_hi[4], ot_warn, code};
      else m_dout = lvl_hi[3:0];
      for (int k = 0; k < N; k++) begin
        if (wok) begin m_cnt[k] = 0; m_trip[k] = 0; end
        else if (!m_trip[k]) begin
          if (drop_hi[k] && cmd_active[k]) begin
            if (m_cnt[k] == TC-1) m_trip[k] = 1;
            else m_cnt[k]++;
          end else m_cnt[k] = 0;
        end
      end
      if (tsd_trip) m_hot = 1;
      else if (tsd_release) m_hot = 0;
      m_force = m_trip | {N{ov_flag}} | {N{m_hot}};
    end
  end

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "model force_off", int'(force_off), int'(m_force));
      check(cur_req, "model bus_oe", int'(bus_oe), int'(m_oe));
      check(cur_req, "model bus_dout", int'(bus_dout), int'(m_dout));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_write();
    sel_n = 0; rd_wr_n = 0; wr_cmd = 1; step(1);
    wr_cmd = 0; sel_n = 1; step(1);
  endtask

  task automatic read_word(bit m);
    sel_n = 0; rd_wr_n = 1; mode = m; step(1);
  endtask

  task automatic end_read();
    sel_n = 1; rd_wr_n = 0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    cur_req = "R11";
    check("R11", "reset force_off", int'(force_off), 0);
    check("R11", "reset bus_oe", int'(bus_oe), 0);
    check("R11", "reset bus_dout", int'(bus_dout), 0);

    // R1: trip after full window
    cur_req = "R1";
    cmd_active = '1;
    drop_hi[0] = 1;
    step(TC-1);
    check("R1", "before window end", int'(force_off[0]), 0);
    step(1);
    check("R1", "after window end", int'(force_off[0]), 1);
    drop_hi[0] = 0;
    step(2);
    check("R1", "trip latched after drop clears", int'(force_off[0]), 1);

    // R7: half-bridge code
    cur_req = "R7";
    lvl_hi = 5'b10000; ot_warn = 1;
    read_word(1);
    check("R7", "code half-bridge", int'(bus_dout), 4'b1101);
    end_read();
    ot_warn = 0;

    // R3: write clears
    cur_req = "R3";
    do_write();
    check("R3", "write clears force_off", int'(force_off), 0);

    // R3: write on the completing edge wins
    drop_hi[1] = 1;
    step(TC-1);
    wr_cmd = 1; sel_n = 0; rd_wr_n = 0;
    step(1);
    wr_cmd = 0; sel_n = 1;
    check("R3", "write beats trip on same edge", int'(force_off[1]), 0);
    step(TC-1);
    check("R3", "fresh window still running", int'(force_off[1]), 0);
    step(1);
    check("R3", "fresh window trips", int'(force_off[1]), 1);
    drop_hi[1] = 0;
    do_write();

    // R2: interrupted window and inactive output
    cur_req = "R2";
    drop_hi[2] = 1; step(TC-1);
    drop_hi[2] = 0; step(1);
    drop_hi[2] = 1; step(TC-1);
    check("R2", "interrupted window no trip", int'(force_off[2]), 0);
    drop_hi[2] = 0;
    cmd_active[3] = 0; drop_hi[3] = 1; step(3*TC);
    check("R2", "inactive output never trips", int'(force_off[3]), 0);
    drop_hi[3] = 0; cmd_active[3] = 1;

    // R7: high-side code, then priority of half-bridge
    cur_req = "R7";
    drop_hi[4] = 1; step(TC); drop_hi[4] = 0;
    check("R7", "high-side forced off", int'(force_off), 5'b10000);
    lvl_hi = 5'b00000;
    read_word(1);
    check("R7", "code high-side", int'(bus_dout), 4'b0010);
    end_read();
    drop_hi[0] = 1; step(TC); drop_hi[0] = 0;
    read_word(1);
    check("R7", "half-bridge beats high-side", int'(bus_dout), 4'b0001);
    end_read();

    // R9: write during read ignored
    cur_req = "R9";
    sel_n = 0; rd_wr_n = 1; mode = 1; wr_cmd = 1; step(1);
    wr_cmd = 0; end_read();
    check("R9", "write in read ignored", int'(force_off), 5'b10001);
    do_write();

    // R10 / R4: overvoltage with a latched trip
    cur_req = "R10";
    drop_hi[2] = 1; step(TC); drop_hi[2] = 0;
    ov_flag = 1; step(1);
    check("R4", "overvoltage forces all", int'(force_off), 5'b11111);
    read_word(1);
    check("R10", "overvoltage code", int'(bus_dout[1:0]), 2'b11);
    end_read();
    ov_flag = 0; step(1);
    check("R4", "resume after overvoltage", int'(force_off), 5'b00100);
    read_word(1);
    check("R10", "trip code returns", int'(bus_dout[1:0]), 2'b01);
    end_read();
    do_write();

    // R5: thermal latch
    cur_req = "R5";
    tsd_trip = 1; step(1); tsd_trip = 0;
    check("R5", "thermal forces all", int'(force_off), 5'b11111);
    step(4);
    check("R5", "thermal holds", int'(force_off), 5'b11111);
    tsd_trip = 1; tsd_release = 1; step(1); tsd_trip = 0;
    check("R5", "trip beats release", int'(force_off), 5'b11111);
    step(1); tsd_release = 0;
    check("R5", "release clears", int'(force_off), 0);

    // R6: level readout
    cur_req = "R6";
    lvl_hi = 5'b01010; read_word(0);
    check("R6", "levels pattern A", int'(bus_dout), 4'b1010);
    lvl_hi = 5'b10101; step(1);
    check("R6", "levels pattern B", int'(bus_dout), 4'b0101);
    end_read();

    // R8: bus drive control
    cur_req = "R8";
    check("R8", "deselected oe", int'(bus_oe), 0);
    check("R8", "deselected data", int'(bus_dout), 0);
    sel_n = 0; rd_wr_n = 0; step(1);
    check("R8", "write cycle oe", int'(bus_oe), 0);
    sel_n = 1; step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule